// File: doc/BRIEF.md
# Separate-port double-data-rate burst-two memory

This block is a synchronous storage array with two independent request ports. In every master clock cycle it can take one read and one write, each with its own word address. Write data travels on a dedicated input bus as two beats: one is captured on the rising edge of a write-data clock and one on the falling edge. The two beats are joined into a double-width word, and that word is stored in a single array access. A read fetches one double-width word. After a fixed pipeline of three master cycles, the word leaves on a separate output bus as two beats: the low beat while the master clock is high and the high beat while it is low. A valid flag covers both beat times.

Each beat is split into byte lanes with individual enables. A partial write merges the new lanes with the corrected old contents, and the error code is then recomputed over the merged word. Every stored word carries a Hamming code. Any single flipped bit in a stored codeword, data or check bit, is repaired on the way out and on the read-modify-write path. A write and a read issued in the same cycle are ordered write first, so a same-address read returns the new data.

Top module: `sqdr_sram`

## Requirements
- R1: While reset is high, and until a read has been accepted and returned, `rd_vld` is 0. During reset `rd_q` is 0 in both clock phases.
- R2: Data for a read captured at rising edge k appears on `rd_q` after rising edge k+3. The low half (beat 0) is driven while the clock is high, and the high half (beat 1) while it is low.
- R3: `rd_vld` is 1 for exactly the cycle that follows rising edge k+3 of each accepted read, covering both beats, and it is 0 in every other cycle.
- R4: A write captured at rising edge k takes beat 0 from `wr_d` on the rising edge of `wr_dclk` in that same cycle and beat 1 on the next falling edge. Both beats are stored together at `wr_addr`, which selects one of 2^ADDR_W two-beat words. A read returns beat 0 first.
- R5: A read and a write to different addresses in the same cycle are both carried out.
- R6: A read issued in the same cycle as a write to the same address returns the new data. A read issued one cycle earlier returns the old data.
- R7: `wr_be` bit i set writes bits [i*LANE_W +: LANE_W] of the current beat (LANE_W = 9 by default). A clear bit leaves those bits unchanged. Enables are sampled per beat, together with the beat's data.
- R8: Flipping any single bit of a stored codeword (data word plus check bits) does not change the data delivered by the decoder.
- R9: Reads issued in consecutive cycles return in consecutive cycles with no gap, in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; commands and output timing |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read word address |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write word address |
| wr_dclk | input | 1 | Write-data capture clock |
| wr_d | input | BEAT_W | Write data beat |
| wr_be | input | LANES | Byte-lane enables for the current beat |
| rd_q | output | BEAT_W | Read data beat |
| rd_vld | output | 1 | Read data valid for both beats |

## Verification
A valid bit left set or cleared wrongly in the read pipeline shows up as `rd_vld` high or low on the wrong edge, four rising edges after the request. The bench compares `rd_vld` on every cycle, so the error is seen at once. Wrong lane steering in the merge stays hidden until that address is read back. The bench then sees one corrupted lane on exactly that beat, three cycles after the read. An encoder and decoder that do not match corrupt the first read of the affected word. A decoder that fails to repair one bit position is exposed by the sweep of all single-bit flips on the codec.

// File: rtl/sqdr_pkg.sv
package sqdr_pkg;

    function automatic logic is_pow2(input int n);
        return (n & (n - 1)) == 0;
    endfunction

    // number of Hamming check bits needed for dw data bits
    function automatic int ecc_bits(input int dw);
        int p;
        p = 0;
        while ((1 << p) < dw + p + 1) p++;
        return p;
    endfunction

endpackage

// File: rtl/sqdr_ecc_enc.sv
module sqdr_ecc_enc #(
    parameter int DW = 36,
    localparam int P = sqdr_pkg::ecc_bits(DW),
    localparam int CW = DW + P
) (
    input  logic [DW-1:0] data,
    output logic [CW-1:0] cw
);
    always_comb begin
        int  di;
        logic par;
        cw = '0;
        di = 0;
        for (int p = 1; p <= CW; p++) begin
            if (!sqdr_pkg::is_pow2(p)) begin
                cw[p-1] = data[di];
                di++;
            end
        end
        for (int i = 0; i < P; i++) begin
            par = 1'b0;
            for (int p = 1; p <= CW; p++)
                if (((p >> i) & 1) == 1) par ^= cw[p-1];
            cw[(1 << i) - 1] = par;
        end
    end
endmodule

// File: rtl/sqdr_ecc_dec.sv
module sqdr_ecc_dec #(
    parameter int DW = 36,
    localparam int P = sqdr_pkg::ecc_bits(DW),
    localparam int CW = DW + P
) (
    input  logic [CW-1:0] cw,
    output logic [DW-1:0] data
);
    always_comb begin
        int syn;
        int di;
        logic [CW-1:0] fixed;
        syn = 0;
        for (int p = 1; p <= CW; p++)
            if (cw[p-1]) syn ^= p;
        fixed = cw;
        if (syn != 0 && syn <= CW) fixed[syn-1] = ~fixed[syn-1];
        data = '0;
        di = 0;
        for (int p = 1; p <= CW; p++) begin
            if (!sqdr_pkg::is_pow2(p)) begin
                data[di] = fixed[p-1];
                di++;
            end
        end
    end
endmodule

// File: rtl/sqdr_wr_demux.sv
module sqdr_wr_demux #(
    parameter int BEAT_W = 18,
    parameter int LANES  = 2
) (
    input  logic              dclk,
    input  logic [BEAT_W-1:0] d,
    input  logic [LANES-1:0]  be,
    output logic [BEAT_W-1:0] beat0,
    output logic [LANES-1:0]  en0,
    output logic [BEAT_W-1:0] beat1,
    output logic [LANES-1:0]  en1
);
    always_ff @(posedge dclk) begin
        beat0 <= d;
        en0   <= be;
    end

    always_ff @(negedge dclk) begin
        beat1 <= d;
        en1   <= be;
    end
endmodule

// File: rtl/sqdr_rd_mux.sv
module sqdr_rd_mux #(
    parameter int BEAT_W = 18
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_v,
    input  logic [2*BEAT_W-1:0] in_word,
    output logic [BEAT_W-1:0]   q,
    output logic                vld
);
    logic [BEAT_W-1:0] lo_r, hi_r, fall_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld  <= 1'b0;
            lo_r <= '0;
            hi_r <= '0;
        end else begin
            vld  <= in_v;
            lo_r <= in_word[BEAT_W-1:0];
            hi_r <= in_word[2*BEAT_W-1:BEAT_W];
        end
    end

    always_ff @(negedge clk) fall_r <= hi_r;

    assign q = clk ? lo_r : fall_r;
endmodule

// File: rtl/sqdr_sram.sv
module sqdr_sram #(
    parameter int BEAT_W = 18,
    parameter int LANES  = 2,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_dclk,
    input  logic [BEAT_W-1:0] wr_d,
    input  logic [LANES-1:0]  wr_be,
    output logic [BEAT_W-1:0] rd_q,
    output logic              rd_vld
);
    localparam int WORD_W = 2 * BEAT_W;
    localparam int LANE_W = BEAT_W / LANES;
    localparam int NLANE  = 2 * LANES;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int CW_W   = WORD_W + sqdr_pkg::ecc_bits(WORD_W);

    typedef struct packed {
        logic              v;
        logic [ADDR_W-1:0] a;
    } req_t;

    req_t rq1, rq2, wq;
    logic [CW_W-1:0]   mem [DEPTH];
    logic [BEAT_W-1:0] b0, b1;
    logic [LANES-1:0]  e0, e1;
    logic [WORD_W-1:0] new_word, old_word, mrg_word, rd_word, s3_d;
    logic [NLANE-1:0]  lane_en;
    logic [CW_W-1:0]   wr_cw;
    logic              s3_v;

    sqdr_wr_demux #(.BEAT_W(BEAT_W), .LANES(LANES)) u_dmx (
        .dclk(wr_dclk), .d(wr_d), .be(wr_be),
        .beat0(b0), .en0(e0), .beat1(b1), .en1(e1)
    );

    assign new_word = {b1, b0};
    assign lane_en  = {e1, e0};

    // read-modify-write source: corrected old contents
    sqdr_ecc_dec #(.DW(WORD_W)) u_dec_old (.cw(mem[wq.a]), .data(old_word));

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        assign mrg_word[l*LANE_W +: LANE_W] =
            lane_en[l] ? new_word[l*LANE_W +: LANE_W] : old_word[l*LANE_W +: LANE_W];
    end

    sqdr_ecc_enc #(.DW(WORD_W)) u_enc (.data(mrg_word), .cw(wr_cw));

    always_ff @(posedge clk) begin
        if (!rst && wq.v) mem[wq.a] <= wr_cw;
    end

    // read path: capture, array access, correction, output
    sqdr_ecc_dec #(.DW(WORD_W)) u_dec_rd (.cw(mem[rq2.a]), .data(rd_word));

    always_ff @(posedge clk) begin
        if (rst) begin
            rq1.v <= 1'b0;
            rq2.v <= 1'b0;
            wq.v  <= 1'b0;
            s3_v  <= 1'b0;
        end else begin
            rq1.v <= rd_en;
            rq2.v <= rq1.v;
            wq.v  <= wr_en;
            s3_v  <= rq2.v;
        end
        rq1.a <= rd_addr;
        rq2.a <= rq1.a;
        wq.a  <= wr_addr;
        s3_d  <= rd_word;
    end

    sqdr_rd_mux #(.BEAT_W(BEAT_W)) u_omx (
        .clk(clk), .rst(rst), .in_v(s3_v), .in_word(s3_d),
        .q(rd_q), .vld(rd_vld)
    );
endmodule

// File: rtl/sqdr_sram_chk.sv
module sqdr_sram_chk #(
    parameter int WORD_W = 36
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic              rd_vld,
    input logic              wr_go,
    input logic [WORD_W-1:0] mrg_word,
    input logic [WORD_W+sqdr_pkg::ecc_bits(WORD_W)-1:0] enc_cw
);
    localparam int CW_W = WORD_W + sqdr_pkg::ecc_bits(WORD_W);

    logic [2:0]        age;
    logic [7:0]        fi;
    logic [CW_W-1:0]   flip_cw;
    logic [WORD_W-1:0] rt_d, fx_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            age <= 3'd0;
            fi  <= 8'd0;
        end else begin
            if (age != 3'd4) age <= age + 3'd1;
            fi <= (fi == 8'(CW_W - 1)) ? 8'd0 : fi + 8'd1;
        end
    end

    assign flip_cw = enc_cw ^ ({{(CW_W-1){1'b0}}, 1'b1} << fi);

    sqdr_ecc_dec #(.DW(WORD_W)) u_rt (.cw(enc_cw),  .data(rt_d));
    sqdr_ecc_dec #(.DW(WORD_W)) u_fx (.cw(flip_cw), .data(fx_d));

    // R1
    early_vld_low_chk: assert property (@(posedge clk) disable iff (rst)
        (age < 3'd4) |-> !rd_vld);

    // R3
    vld_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (age == 3'd4) |-> (rd_vld == $past(rd_en, 4)));

    // R7
    merge_encode_chk: assert property (@(posedge clk) disable iff (rst)
        wr_go |-> (rt_d == mrg_word));

    // R8
    single_flip_chk: assert property (@(posedge clk) disable iff (rst)
        wr_go |-> (fx_d == mrg_word));
endmodule

bind sqdr_sram sqdr_sram_chk #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_vld(rd_vld),
    .wr_go(wq.v), .mrg_word(mrg_word), .enc_cw(wr_cw)
);

// File: tb/sim_sqdr_sram.sv
module sim_sqdr_sram;
    localparam int BW = 18;
    localparam int AW = 5;
    localparam int NL = 2;
    localparam int WW = 2 * BW;
    localparam int CW = WW + sqdr_pkg::ecc_bits(WW);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rd_en = 1'b0, wr_en = 1'b0;
    logic [AW-1:0] rd_addr = '0, wr_addr = '0;
    logic [BW-1:0] wr_d = '0;
    logic [NL-1:0] wr_be = '0;
    logic [BW-1:0] rd_q;
    logic rd_vld;

    always #4 clk = ~clk;

    sqdr_sram #(.BEAT_W(BW), .LANES(NL), .ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_dclk(clk),
        .wr_d(wr_d), .wr_be(wr_be), .rd_q(rd_q), .rd_vld(rd_vld)
    );

    // standalone codec for the bit-flip sweep
    logic [WW-1:0] t_d, t_out;
    logic [CW-1:0] t_cw, t_bad;
    sqdr_ecc_enc #(.DW(WW)) u_tenc (.data(t_d), .cw(t_cw));
    sqdr_ecc_dec #(.DW(WW)) u_tdec (.cw(t_bad), .data(t_out));

    int n_cmp = 0, n_bad = 0;
    string cur_req = "R2";

    logic [WW-1:0] mdl [1<<AW];
    bit            mk  [1<<AW];
    bit            pv  [4];
    bit            pk  [4];
    logic [WW-1:0] pd  [4];

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [BW-1:0] pat(input int i);
        return BW'((i * 32'h9E37 + 32'h1234) ^ (i << 7));
    endfunction

    // one master cycle; called at a quarter period before the rising edge
    task automatic step(input bit re, input int ra, input bit we, input int wa,
                        input logic [BW-1:0] d0, input logic [BW-1:0] d1,
                        input logic [NL-1:0] m0, input logic [NL-1:0] m1);
        logic [WW-1:0]   nw;
        logic [2*NL-1:0] en;
        rd_en = re; rd_addr = AW'(ra);
        wr_en = we; wr_addr = AW'(wa);
        wr_d = d0; wr_be = m0;
        if (we) begin
            nw = {d1, d0};
            en = {m1, m0};
            for (int l = 0; l < 2*NL; l++)
                if (en[l]) mdl[wa][l*(BW/NL) +: BW/NL] = nw[l*(BW/NL) +: BW/NL];
            mk[wa] = 1'b1;
        end
        for (int s = 3; s > 0; s--) begin
            pv[s] = pv[s-1]; pk[s] = pk[s-1]; pd[s] = pd[s-1];
        end
        pv[0] = re;
        pk[0] = re && mk[ra];
        pd[0] = mdl[ra];
        @(posedge clk); #2;
        check(rd_vld == pv[3], "R3", 64'(rd_vld), 64'(pv[3]));
        if (pv[3] && pk[3]) check(rd_q == pd[3][BW-1:0], cur_req, 64'(rd_q), 64'(pd[3][BW-1:0]));
        wr_d = d1; wr_be = m1;
        @(negedge clk); #2;
        if (pv[3] && pk[3]) check(rd_q == pd[3][WW-1:BW], cur_req, 64'(rd_q), 64'(pd[3][WW-1:BW]));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, '0, '0, '0, '0);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #1600000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < (1<<AW); i++) begin mk[i] = 1'b0; mdl[i] = '0; end
        for (int i = 0; i < 4; i++) begin pv[i] = 1'b0; pk[i] = 1'b0; pd[i] = '0; end

        // R1: reset state in both phases
        repeat (3) @(posedge clk);
        #2;
        check(rd_vld == 1'b0, "R1", 64'(rd_vld), 64'd0);
        check(rd_q == '0, "R1", 64'(rd_q), 64'd0);
        @(negedge clk); #2;
        check(rd_q == '0, "R1", 64'(rd_q), 64'd0);
        check(rd_vld == 1'b0, "R1", 64'(rd_vld), 64'd0);
        rst = 1'b0;
        idle(3);

        // R4 / R2: full writes, then reads of them
        cur_req = "R4";
        for (int a = 0; a < 8; a++) step(0, 0, 1, a, pat(2*a), pat(2*a+1), 2'b11, 2'b11);
        idle(1);
        cur_req = "R2";
        step(1, 3, 0, 0, '0, '0, '0, '0);
        idle(5);

        // R9: streaming reads every cycle
        cur_req = "R9";
        for (int a = 7; a >= 0; a--) step(1, a, 0, 0, '0, '0, '0, '0);
        idle(4);

        // R5: read and write to different addresses together
        cur_req = "R5";
        for (int a = 0; a < 6; a++) step(1, a, 1, a + 8, pat(100+a), pat(200+a), 2'b11, 2'b11);
        for (int a = 8; a < 14; a++) step(1, a, 0, 0, '0, '0, '0, '0);
        idle(4);

        // R6: read one cycle early sees old, same cycle sees new
        cur_req = "R6";
        step(1, 2, 0, 0, '0, '0, '0, '0);
        step(1, 2, 1, 2, 18'h2AAAA, 18'h15555, 2'b11, 2'b11);
        step(1, 2, 1, 2, 18'h0F0F0, 18'h30303, 2'b11, 2'b11);
        step(1, 2, 0, 0, '0, '0, '0, '0);
        idle(4);

        // R7: lane enables per beat
        cur_req = "R7";
        step(0, 0, 1, 20, 18'h3FFFF, 18'h3FFFF, 2'b11, 2'b11);
        step(0, 0, 1, 20, 18'h00000, 18'h00000, 2'b01, 2'b10);
        step(1, 20, 1, 21, 18'h12345, 18'h2BCDE, 2'b11, 2'b11);
        step(0, 0, 1, 21, 18'h00001, 18'h3FFFE, 2'b10, 2'b00);
        step(1, 21, 1, 21, 18'h0AAAA, 18'h05555, 2'b00, 2'b01);
        step(1, 21, 0, 0, '0, '0, '0, '0);
        idle(4);

        // full array pass: concurrent fill and readback
        cur_req = "R4";
        for (int a = 0; a < (1<<AW); a++)
            step(a > 0, (a + 31) % 32, 1, a, pat(300+a), pat(400+a), 2'b11, 2'b11);
        for (int a = (1<<AW) - 1; a >= 0; a--) step(1, a, 0, 0, '0, '0, '0, '0);
        idle(4);

        // R8: every single-bit flip of a codeword is repaired
        for (int k = 0; k < 3; k++) begin
            t_d = {pat(7*k+1), pat(7*k+2)};
            #1;
            for (int b = 0; b < CW; b++) begin
                t_bad = t_cw ^ (CW'(1) << b);
                #1;
                check(t_out == t_d, "R8", 64'(t_out), 64'(t_d));
            end
            t_bad = t_cw;
            #1;
            check(t_out == t_d, "R8", 64'(t_out), 64'(t_d));
        end

        summary();
        $finish;
    end
endmodule